// File: doc/BRIEF.md
# RS-485 Transceiver Enable Controller

This block drives the driver-enable and receiver-enable pins of an external RS-485 line transceiver that sits next to a UART. Software configures it through three small registers: a control register, a driver gate register and a receiver gate register. The control register holds a master enable, the polarity of each pin and a two-bit transfer mode.

The UART supplies three status inputs:
- a "transmit data pending" flag (FIFO or shifter holds data);
- a "transmit frame active" flag;
- a "receive frame active" flag.

It also supplies a one-per-bit-time strobe. In the full-duplex and software-directed modes, each pin follows its gate register. In the automatic mode, a small turnaround state machine switches the line between driving and listening. It holds the driver on for a programmable number of bit times after the last stop bit, and it brings the receiver back only after the driver has been released. In every mode, a receive frame that is already under way keeps the receiver enabled until that frame ends, even if software clears the receiver gate.

Writes use a one-cycle strobe with address and data. Reads are combinational on a separate read address. The pins are registered by default, so they follow the internal decision one clock later.

Top module: `rs485x_ctl`

## Requirements
- R1: After reset the control register reads 0x04, both gate registers read 0, `de_pin` is 0 and `re_pin` is 1.
- R2: While control bit 0 (enable) is 0, both pins sit at their inactive levels regardless of every other input.
- R3: Control bit 1 selects `re_pin` polarity and control bit 2 selects `de_pin` polarity (1 = active-high, 0 = active-low). The pins change one clock after the internal decision.
- R4: Control bits 4:3 hold the mode: 0 full duplex, 1 software-directed, 2 automatic, and 3 behaves exactly like 2.
- R5: The control register is at address 0, the driver gate is at address 1 and the receiver gate is at address 2. Each gate implements only bit 0. Reads return 0 in unimplemented bits, and the control register keeps only bits 4:0.
- R6: In modes 0 and 1, the driver is asserted exactly when the driver gate is 1, and the receiver is asserted when the receiver gate is 1. Both may be asserted together.
- R7: If the receiver gate is cleared while `rx_busy` is high and the receiver is asserted, the receiver stays asserted until `rx_busy` falls.
- R8: In automatic mode, with the driver gate set, pending transmit data asserts the driver and deasserts the receiver. With the driver gate clear, the line stays in receive.
- R9: In automatic mode, once no data is pending and no frame is active, the driver stays asserted until `TAIL_BITS` bit strobes have passed. It then drops, and the receiver re-asserts one clock later. The two are never asserted together.
- R10: A write to an unmapped address changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |
| tx_pending | input | 1 | Transmit FIFO or shifter holds data |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_busy | input | 1 | Receive frame in progress |
| bit_tick | input | 1 | One-cycle strobe once per bit time |
| de_pin | output | 1 | Driver-enable pin to the transceiver |
| re_pin | output | 1 | Receiver-enable pin to the transceiver |

## Verification
The embedded properties check the following on every cycle:
- the disabled state forces both internal enables off;
- the automatic mode never asserts driver and receiver together, and re-asserts the receiver only after the driver was off;
- the turnaround machine always leaves its gap state for receive;
- the receive-hold latch never drops mid-frame;
- gate writes read back, and unmapped writes disturb nothing.

Only the bench scenarios show the following:
- the pin-level polarity for every control value and gate combination;
- the exact clock on which the driver is released after the tail bit strobe;
- the one-clock gap before receive returns;
- that mode 3 matches mode 2.

// File: rtl/rs485x_pkg.sv
package rs485x_pkg;

   typedef enum logic [1:0] {
      XM_DUPLEX   = 2'd0,
      XM_DIRECT   = 2'd1,
      XM_AUTO     = 2'd2,
      XM_AUTO_ALT = 2'd3
   } xmode_e;

   typedef enum logic [1:0] {
      TS_RX   = 2'd0,
      TS_TX   = 2'd1,
      TS_TAIL = 2'd2,
      TS_GAP  = 2'd3
   } tstate_e;

   // packed MSB first: mode[4:3], de_pol[2], re_pol[1], en[0]
   typedef struct packed {
      logic [1:0] mode;
      logic       de_pol;
      logic       re_pol;
      logic       en;
   } xctrl_t;

   localparam int    CTRL_BITS = 5;
   localparam xctrl_t CTRL_RST = '{mode: 2'd0, de_pol: 1'b1, re_pol: 1'b0, en: 1'b0};

endpackage

// File: rtl/rs485x_regs.sv
module rs485x_regs
   import rs485x_pkg::*;
#(
   parameter int AW        = 2,
   parameter int DW        = 8,
   parameter int CTRL_ADDR = 0,
   parameter int DEEN_ADDR = 1,
   parameter int REEN_ADDR = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output xctrl_t        ctrl,
   output logic          de_gate,
   output logic          re_gate
);

   localparam logic [AW-1:0] A_CTRL = AW'(CTRL_ADDR);
   localparam logic [AW-1:0] A_DEEN = AW'(DEEN_ADDR);
   localparam logic [AW-1:0] A_REEN = AW'(REEN_ADDR);
   localparam int            PADW   = DW - CTRL_BITS;

   initial begin
      assert (DW >= CTRL_BITS) else $error("rs485x_regs: DW too narrow for control");
      assert (CTRL_ADDR < (1 << AW) && DEEN_ADDR < (1 << AW) && REEN_ADDR < (1 << AW))
         else $error("rs485x_regs: address outside AW range");
      assert (CTRL_ADDR != DEEN_ADDR && CTRL_ADDR != REEN_ADDR && DEEN_ADDR != REEN_ADDR)
         else $error("rs485x_regs: address collision");
   end

   logic hit_ctrl, hit_deen, hit_reen;
   assign hit_ctrl = wr_en && (wr_addr == A_CTRL);
   assign hit_deen = wr_en && (wr_addr == A_DEEN);
   assign hit_reen = wr_en && (wr_addr == A_REEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= CTRL_RST;
         de_gate <= 1'b0;
         re_gate <= 1'b0;
      end else begin
         if (hit_ctrl) ctrl    <= xctrl_t'(wr_data[CTRL_BITS-1:0]);
         if (hit_deen) de_gate <= wr_data[0];
         if (hit_reen) re_gate <= wr_data[0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL)      rd_data = {{PADW{1'b0}}, ctrl};
      else if (rd_addr == A_DEEN) rd_data = {{(DW-1){1'b0}}, de_gate};
      else if (rd_addr == A_REEN) rd_data = {{(DW-1){1'b0}}, re_gate};
   end

   // R5: gate writes keep bit 0 only
   a_r5_gate_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_DEEN) |=> (de_gate == $past(wr_data[0])));

   // R10: unmapped writes leave every register alone
   a_r10_unmapped_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != A_CTRL && wr_addr != A_DEEN && wr_addr != A_REEN)
      |=> ($stable(ctrl) && $stable(de_gate) && $stable(re_gate)));

endmodule

// File: rtl/rs485x_rxhold.sv
module rs485x_rxhold (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_in,
   input  logic rx_busy,
   output logic gate_out
);

   logic held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= gate_in | (held_q & rx_busy);
   end

   assign gate_out = gate_in | (held_q & rx_busy);

   // R7: an open receive window survives until the frame ends
   a_r7_hold_frame : assert property (@(posedge clk) disable iff (!rst_n)
      (gate_out && rx_busy) |=> (gate_out || !rx_busy));

endmodule

// File: rtl/rs485x_turn.sv
module rs485x_turn
   import rs485x_pkg::*;
#(
   parameter int TAIL_BITS = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    auto_on,
   input  logic    de_gate,
   input  logic    tx_pending,
   input  logic    tx_busy,
   input  logic    bit_tick,
   output tstate_e st_q
);

   localparam int CW = (TAIL_BITS > 1) ? $clog2(TAIL_BITS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TAIL_BITS - 1);

   initial begin
      assert (TAIL_BITS >= 1) else $error("rs485x_turn: TAIL_BITS must be at least 1");
   end

   tstate_e       st_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (!auto_on) begin
         st_d  = TS_RX;
         cnt_d = '0;
      end else begin
         unique case (st_q)
            TS_RX:   if (de_gate && tx_pending) st_d = TS_TX;
            TS_TX:   if (!tx_pending && !tx_busy) begin
                        st_d  = TS_TAIL;
                        cnt_d = '0;
                     end
            TS_TAIL: if (tx_pending) st_d = TS_TX;
                     else if (bit_tick) begin
                        if (cnt_q == LAST) st_d = TS_GAP;
                        else               cnt_d = cnt_q + 1'b1;
                     end
            TS_GAP:  st_d = TS_RX;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TS_RX;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   // R9: the gap state lasts exactly one cycle and leads to receive
   a_r9_gap_to_rx : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TS_GAP) |=> (st_q == TS_RX));

   // R9: an idle transmitter always leaves the transmit state
   a_r9_leave_tx : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TS_TX && !tx_pending && !tx_busy) |=> (st_q != TS_TX));

endmodule

// File: rtl/rs485x_drive.sv
module rs485x_drive
   import rs485x_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic de_act,
   input  logic re_act,
   input  logic de_pol,
   input  logic re_pol,
   output logic de_pin,
   output logic re_pin
);

   logic de_lvl, re_lvl;
   assign de_lvl = de_pol ? de_act : ~de_act;
   assign re_lvl = re_pol ? re_act : ~re_act;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               de_pin <= ~CTRL_RST.de_pol;
               re_pin <= ~CTRL_RST.re_pol;
            end else begin
               de_pin <= de_lvl;
               re_pin <= re_lvl;
            end
         end
      end else begin : g_comb
         assign de_pin = de_lvl;
         assign re_pin = re_lvl;
      end
   endgenerate

endmodule

// File: rtl/rs485x_ctl.sv
module rs485x_ctl
   import rs485x_pkg::*;
#(
   parameter int AW        = 2,
   parameter int DW        = 8,
   parameter int TAIL_BITS = 1,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          tx_pending,
   input  logic          tx_busy,
   input  logic          rx_busy,
   input  logic          bit_tick,
   output logic          de_pin,
   output logic          re_pin
);

   xctrl_t  ctrl;
   logic    de_gate, re_gate_raw, re_gate;
   logic    auto_on, de_act, re_act;
   tstate_e st;

   rs485x_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ctrl(ctrl),
      .de_gate(de_gate), .re_gate(re_gate_raw)
   );

   rs485x_rxhold u_hold (
      .clk(clk), .rst_n(rst_n), .gate_in(re_gate_raw), .rx_busy(rx_busy), .gate_out(re_gate)
   );

   // mode values 2 and 3 both select automatic turnaround
   assign auto_on = ctrl.en && ctrl.mode[1];

   rs485x_turn #(.TAIL_BITS(TAIL_BITS)) u_turn (
      .clk(clk), .rst_n(rst_n), .auto_on(auto_on), .de_gate(de_gate),
      .tx_pending(tx_pending), .tx_busy(tx_busy), .bit_tick(bit_tick), .st_q(st)
   );

   always_comb begin
      de_act = 1'b0;
      re_act = 1'b0;
      if (ctrl.en) begin
         if (ctrl.mode[1]) begin
            de_act = de_gate && (st == TS_TX || st == TS_TAIL);
            re_act = re_gate && (st == TS_RX);
         end else begin
            de_act = de_gate;
            re_act = re_gate;
         end
      end
   end

   rs485x_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk(clk), .rst_n(rst_n), .de_act(de_act), .re_act(re_act),
      .de_pol(ctrl.de_pol), .re_pol(ctrl.re_pol), .de_pin(de_pin), .re_pin(re_pin)
   );

   // R2: a disabled controller asserts neither side
   a_r2_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> (!de_act && !re_act));

   // R9: automatic mode never drives and listens at once
   a_r9_interlock : assert property (@(posedge clk) disable iff (!rst_n)
      auto_on |-> !(de_act && re_act));

   // R9: receive returns only after the driver was already off
   a_r9_break_before_make : assert property (@(posedge clk) disable iff (!rst_n)
      (auto_on && $past(auto_on) && $rose(re_act)) |-> !$past(de_act));

endmodule

// File: tb/sim_rs485x_ctl.sv
`timescale 1ns/1ps
module sim_rs485x_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       tx_pending = 1'b0, tx_busy = 1'b0, rx_busy = 1'b0, bit_tick = 1'b0;
   logic       de_pin, re_pin;
   int         checks = 0;
   int         errors = 0;

   always #2.5 clk = ~clk;

   rs485x_ctl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_pending(tx_pending), .tx_busy(tx_busy),
      .rx_busy(rx_busy), .bit_tick(bit_tick), .de_pin(de_pin), .re_pin(re_pin)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      rd_addr = 2'(a);
      #0.5;
      d = int'(rd_data);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int v;
      settle(3);
      rst_n = 1'b1;
      settle(2);
      // R1 reset state
      rd(0, v); chk("R1 ctrl reset", v, 8'h04);
      rd(1, v); chk("R1 de gate reset", v, 0);
      rd(2, v); chk("R1 re gate reset", v, 0);
      chk("R1 de_pin reset", de_pin, 0);
      chk("R1 re_pin reset", re_pin, 1);

      // R2 R3 R4 R6: exhaustive sweep of control values and gates, idle line
      for (int c = 0; c < 32; c++) begin
         wr(0, c | 8'hE0);
         rd(0, v); chk("R5 ctrl readback", v, c);
         for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < 2; r++) begin
               bit en, rp, dp, de_a, re_a;
               int m;
               wr(1, d); wr(2, r);
               settle(2);
               en = c[0]; rp = c[1]; dp = c[2]; m = (c >> 3) & 3;
               de_a = en && (m < 2) && (d == 1);
               re_a = en && (r == 1);
               chk("R2 R3 R4 R6 de_pin sweep", de_pin, dp ? de_a : !de_a);
               chk("R2 R3 R4 R6 re_pin sweep", re_pin, rp ? re_a : !re_a);
            end
         end
      end

      // R5 gate width
      wr(1, 8'hFF); rd(1, v); chk("R5 de gate bit0 only", v, 1);
      wr(2, 8'hFE); rd(2, v); chk("R5 re gate bit0 only", v, 0);

      // R10 unmapped address 3
      wr(0, 8'h0D); wr(1, 1); wr(2, 1); settle(2);
      wr(3, 8'hFF); settle(2);
      rd(0, v); chk("R10 ctrl untouched", v, 8'h0D);
      rd(1, v); chk("R10 de gate untouched", v, 1);
      rd(2, v); chk("R10 re gate untouched", v, 1);
      chk("R10 de_pin untouched", de_pin, 1);
      chk("R10 re_pin untouched", re_pin, 0);

      // R7 receive hold in direct mode (0x0D: en, de active-high, re active-low, mode 1)
      @(negedge clk) rx_busy = 1'b1;
      wr(2, 0); settle(3);
      chk("R7 re held during frame", re_pin, 0);
      @(negedge clk) rx_busy = 1'b0;
      settle(1);
      chk("R7 re released at frame end", re_pin, 1);
      wr(2, 1); settle(2);
      chk("R7 re back on", re_pin, 0);

      // R8 R9 automatic mode 2 (0x15) and mode 3 (0x1D)
      for (int k = 0; k < 2; k++) begin
         string md;
         md = (k == 0) ? "mode2" : "mode3";
         wr(0, (k == 0) ? 8'h15 : 8'h1D); settle(2);
         chk({"R8 idle re on ", md}, re_pin, 0);
         chk({"R8 idle de off ", md}, de_pin, 0);
         @(negedge clk) tx_pending = 1'b1;
         settle(1);
         @(negedge clk);
         chk({"R8 de on ", md}, de_pin, 1);
         chk({"R8 re off ", md}, re_pin, 1);
         @(negedge clk) begin tx_pending = 1'b0; tx_busy = 1'b1; end
         settle(3);
         chk({"R9 de kept while busy ", md}, de_pin, 1);
         @(negedge clk) tx_busy = 1'b0;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk({"R9 de held in tail ", md}, de_pin, 1);
            chk({"R9 re off in tail ", md}, re_pin, 1);
         end
         bit_tick = 1'b1;
         @(negedge clk) bit_tick = 1'b0;
         @(negedge clk);
         chk({"R9 de released ", md}, de_pin, 0);
         chk({"R9 re still off in gap ", md}, re_pin, 1);
         @(negedge clk);
         chk({"R9 re returns ", md}, re_pin, 0);
         chk({"R9 de stays off ", md}, de_pin, 0);
      end

      // R8 driver gate clear blocks transmit turnaround
      wr(1, 0);
      @(negedge clk) tx_pending = 1'b1;
      settle(4);
      chk("R8 no drive with gate clear", de_pin, 0);
      chk("R8 still listening", re_pin, 0);
      @(negedge clk) tx_pending = 1'b0;

      // R2 disable during automatic drive
      wr(1, 1);
      @(negedge clk) tx_pending = 1'b1;
      settle(3);
      chk("R2 auto drive before disable", de_pin, 1);
      wr(0, 8'h14); settle(2);
      chk("R2 de inactive when disabled", de_pin, 0);
      chk("R2 re inactive when disabled", re_pin, 1);
      @(negedge clk) tx_pending = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule